// File: doc/BRIEF.md
# Eight-Line GPIO Expander Register Bank

This block is the register file and pin-control datapath of an 8-line general-purpose I/O expander. A serial bus front end, outside this block, turns bus transactions into single-byte register reads and writes on a simple port. That port carries an address, write data, a write strobe, a read strobe and registered read data. The block stores the per-pin configuration and drives four per-pin controls toward the pad ring: output enable, output value, pull-up enable and pull-down enable. It also samples the pin levels through a synchronizer so they can be read back.

Each pin has several configuration bits. A direction bit selects output or input. A float bit overrides the direction bit and stops the output driver. A pull enable bit turns on a resistor for input pins only, and a pull-select bit picks the direction of that pull.

An identification/control byte gives a fixed vendor code and a revision number. It also carries a reset-indication flag that a read clears, and a write-only soft reset bit. The interrupt mask and the expected-level registers are stored here and exported to a separate interrupt block. That block also owns the interrupt status location.

Top module: `gpio_expander_regs`

## Requirements
- R1: After reset every pin is an input (pin_oe = 0x00, pin_out = 0x00), pull-up is active on all pins (pin_pu = 0xFF, pin_pd = 0x00), and irq_mask_o = 0xFF, irq_dflt_o = 0x00. Reading back gives direction (0x03) = 0x00, float (0x07) = 0xFF, pull enable (0x0B) = 0xFF and pull select (0x0D) = 0xFF.
- R2: The direction register is at 0x03, with 1 = output. The output level register is at 0x05. pin_out equals the output level register, and pin_oe[i] is 1 only when direction[i] = 1 and float[i] = 0. Both pin_out and pin_oe change in the first cycle after the write edge.
- R3: A 1 in the float register (0x07) forces pin_oe[i] = 0 even when the pin is an output.
- R4: A pull is active only on input pins whose pull enable bit (0x0B) is 1. pin_pu[i] = 1 when the pull select bit (0x0D) is 1, and pin_pd[i] = 1 when it is 0. pin_pu and pin_pd are never both set, and neither is set on a driven pin.
- R5: Reading 0x01 returns {3'b101, REV_CODE[2:0], flag, 1'b0}: the vendor code in bits 7:5, the revision in bits 4:2, the reset flag in bit 1, and bit 0 always 0. With the default REV_CODE = 2 this reads 0xAA while the flag is set and 0xA8 once it is clear.
- R6: Reading 0x01 clears the reset flag after the value is returned. Both hardware reset and soft reset set the flag again.
- R7: Writing 0x01 with bit 0 = 1 returns every stored register to its R1 value at that clock edge.
- R8: Reading 0x0F returns the pin levels after a two-flop synchronizer. A pin change is seen by a read whose strobe is at least two cycles later. A read strobed in the cycle right after the change returns the old level. Writes to 0x0F have no effect.
- R9: Reads from any address other than 0x01, 0x03, 0x05, 0x07, 0x09, 0x0B, 0x0D, 0x0F and 0x11 return 0x00. Writes to such addresses change no register; 0x13 is included, since the interrupt block owns it.
- R10: reg_rdata updates at the clock edge where reg_rd is high and holds its value in all other cycles.
- R11: The interrupt mask register (0x11) and the expected-level register (0x09) can be read and written, and they drive irq_mask_o and irq_dflt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from pads |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |
| pin_pd | output | 8 | Per-pin pull-down enable |
| irq_mask_o | output | 8 | Interrupt mask to the interrupt block |
| irq_dflt_o | output | 8 | Expected input levels to the interrupt block |

## Verification
The pin controls are combinational from the stored registers. They are due in the first cycle after a write edge, so the bench drives strobes on the falling edge and checks the pins at the next falling edge. Read data is registered and is sampled one falling edge after the read strobe. Pin input changes go through two extra flops, so the bench issues one read a single cycle after a change to confirm the old level, and a second read after three cycles to confirm the new level.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int GPX_W  = 8;
    localparam int GPX_AW = 8;

    localparam logic [GPX_AW-1:0] A_IDCTL = 8'h01;
    localparam logic [GPX_AW-1:0] A_DIR   = 8'h03;
    localparam logic [GPX_AW-1:0] A_OUT   = 8'h05;
    localparam logic [GPX_AW-1:0] A_FLOAT = 8'h07;
    localparam logic [GPX_AW-1:0] A_DFLT  = 8'h09;
    localparam logic [GPX_AW-1:0] A_PEN   = 8'h0B;
    localparam logic [GPX_AW-1:0] A_PSEL  = 8'h0D;
    localparam logic [GPX_AW-1:0] A_LEVEL = 8'h0F;
    localparam logic [GPX_AW-1:0] A_MASK  = 8'h11;

    localparam logic [2:0] VENDOR_CODE = 3'b101;

    typedef struct packed {
        logic [GPX_W-1:0] dir;
        logic [GPX_W-1:0] outv;
        logic [GPX_W-1:0] flt;
        logic [GPX_W-1:0] dflt;
        logic [GPX_W-1:0] pen;
        logic [GPX_W-1:0] psel;
        logic [GPX_W-1:0] mask;
        logic             rflag;
    } gpx_regs_t;

    localparam gpx_regs_t GPX_RST = '{
        dir:   '0,
        outv:  '0,
        flt:   '1,
        dflt:  '0,
        pen:   '1,
        psel:  '1,
        mask:  '1,
        rflag: 1'b1
    };
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = din;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_pin_drive.sv
module gpx_pin_drive #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] outv,
    input  logic [W-1:0] flt,
    input  logic [W-1:0] pen,
    input  logic [W-1:0] psel,
    output logic [W-1:0] oe,
    output logic [W-1:0] ov,
    output logic [W-1:0] pu,
    output logic [W-1:0] pd
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic is_in;
            assign is_in = ~dir[i];
            assign oe[i] = dir[i] & ~flt[i];
            assign ov[i] = outv[i];
            assign pu[i] = is_in & pen[i] &  psel[i];
            assign pd[i] = is_in & pen[i] & ~psel[i];
        end
    endgenerate

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pu & pd) == '0); // R4
    AST_NO_PULL_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu | pd) & oe) == '0); // R4
    AST_FLOAT_STOPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & flt) == '0); // R3
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter logic [2:0] REV_CODE = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPX_AW-1:0] addr,
    input  logic [GPX_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [GPX_W-1:0]  level,
    output gpx_regs_t         regs,
    output logic [GPX_W-1:0]  rdata
);
    typedef struct packed {
        gpx_regs_t        r;
        logic [GPX_W-1:0] rdata;
    } gpx_state_t;

    gpx_state_t st_d, st_q;
    logic       mapped;

    always_comb begin
        st_d   = st_q;
        mapped = 1'b1;
        if (rd) begin
            unique case (addr)
                A_IDCTL: st_d.rdata = {VENDOR_CODE, REV_CODE, st_q.r.rflag, 1'b0};
                A_DIR:   st_d.rdata = st_q.r.dir;
                A_OUT:   st_d.rdata = st_q.r.outv;
                A_FLOAT: st_d.rdata = st_q.r.flt;
                A_DFLT:  st_d.rdata = st_q.r.dflt;
                A_PEN:   st_d.rdata = st_q.r.pen;
                A_PSEL:  st_d.rdata = st_q.r.psel;
                A_LEVEL: st_d.rdata = level;
                A_MASK:  st_d.rdata = st_q.r.mask;
                default: begin
                    st_d.rdata = '0;
                    mapped     = 1'b0;
                end
            endcase
            if (addr == A_IDCTL) st_d.r.rflag = 1'b0;
        end
        if (wr) begin
            unique case (addr)
                A_IDCTL: if (wdata[0]) st_d.r = GPX_RST;
                A_DIR:   st_d.r.dir  = wdata;
                A_OUT:   st_d.r.outv = wdata;
                A_FLOAT: st_d.r.flt  = wdata;
                A_DFLT:  st_d.r.dflt = wdata;
                A_PEN:   st_d.r.pen  = wdata;
                A_PSEL:  st_d.r.psel = wdata;
                A_MASK:  st_d.r.mask = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{r: GPX_RST, rdata: '0};
        else        st_q <= st_d;
    end

    assign regs  = st_q.r;
    assign rdata = st_q.rdata;

    AST_FLAG_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_IDCTL && !(wr && addr == A_IDCTL)) |=> !regs.rflag); // R6
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_IDCTL && wdata[0]) |=> (regs == GPX_RST)); // R7
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0)); // R9
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R10
    AST_ID_LOW_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_IDCTL) |=> (rdata[0] == 1'b0 && rdata[7:5] == VENDOR_CODE)); // R5
endmodule

// File: rtl/gpio_expander_regs.sv
module gpio_expander_regs
    import gpx_pkg::*;
#(
    parameter logic [2:0] REV_CODE    = 3'd2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_oe,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_pu,
    output logic [7:0]  pin_pd,
    output logic [7:0]  irq_mask_o,
    output logic [7:0]  irq_dflt_o
);
    gpx_regs_t        regs;
    logic [GPX_W-1:0] level;

    gpx_sync #(.W(GPX_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (level)
    );

    gpx_regfile #(.REV_CODE(REV_CODE)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .level(level),
        .regs (regs),
        .rdata(reg_rdata)
    );

    gpx_pin_drive #(.W(GPX_W)) u_drive (
        .clk  (clk),
        .rst_n(rst_n),
        .dir  (regs.dir),
        .outv (regs.outv),
        .flt  (regs.flt),
        .pen  (regs.pen),
        .psel (regs.psel),
        .oe   (pin_oe),
        .ov   (pin_out),
        .pu   (pin_pu),
        .pd   (pin_pd)
    );

    assign irq_mask_o = regs.mask;
    assign irq_dflt_o = regs.dflt;

    AST_OE_NEEDS_OUTPUT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~regs.dir) == '0); // R2
endmodule

// File: tb/gpio_expander_regs_test.sv
module gpio_expander_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, pin_in = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata, pin_oe, pin_out, pin_pu, pin_pd, irq_mask_o, irq_dflt_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_expander_regs uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_pu(pin_pu), .pin_pd(pin_pd),
        .irq_mask_o(irq_mask_o), .irq_dflt_o(irq_dflt_o)
    );

    // {addr, data, exp_oe, exp_out, exp_pu, exp_pd}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h03, 8'h0F, 8'h00, 8'h00, 8'hF0, 8'h00},
        {8'h07, 8'h00, 8'h0F, 8'h00, 8'hF0, 8'h00},
        {8'h05, 8'hA5, 8'h0F, 8'hA5, 8'hF0, 8'h00},
        {8'h0D, 8'h30, 8'h0F, 8'hA5, 8'h30, 8'hC0},
        {8'h0B, 8'h60, 8'h0F, 8'hA5, 8'h20, 8'h40},
        {8'h07, 8'h05, 8'h0A, 8'hA5, 8'h20, 8'h40},
        {8'h03, 8'hF0, 8'hF0, 8'hA5, 8'h00, 8'h00},
        {8'h0B, 8'hFF, 8'hF0, 8'hA5, 8'h00, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 pu", pin_pu, 8'hFF);
        check("R1 pd", pin_pd, 8'h00);
        check("R1 mask", irq_mask_o, 8'hFF);
        check("R1 dflt", irq_dflt_o, 8'h00);
        rd(8'h07, rv); check("R1 float", rv, 8'hFF);
        rd(8'h0B, rv); check("R1 pen", rv, 8'hFF);
        rd(8'h03, rv); check("R1 dir", rv, 8'h00);
        // R5 R6 identification byte and flag clearing
        rd(8'h01, rv); check("R5 id with flag", rv, 8'hAA);
        rd(8'h01, rv); check("R6 flag cleared", rv, 8'hA8);
        // R10 read data holds while no read strobe
        repeat (3) @(negedge clk);
        check("R10 rdata hold", reg_rdata, 8'hA8);

        // R2 R3 R4 vector table
        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k][47:40], VEC[k][39:32]);
            check("R2 oe", pin_oe, VEC[k][31:24]);
            check("R2 out", pin_out, VEC[k][23:16]);
            check("R4 pu", pin_pu, VEC[k][15:8]);
            check("R4 pd", pin_pd, VEC[k][7:0]);
            rd(VEC[k][47:40], rv);
            check("R3 readback", rv, VEC[k][39:32]);
        end

        // R9 unmapped locations
        rd(8'h02, rv); check("R9 read 0x02", rv, 8'h00);
        wr(8'h02, 8'h55);
        wr(8'h13, 8'h55);
        rd(8'h13, rv); check("R9 read 0x13", rv, 8'h00);
        rd(8'h03, rv); check("R9 dir untouched", rv, 8'hF0);
        check("R9 oe untouched", pin_oe, 8'hF0);

        // R11 interrupt side registers
        wr(8'h11, 8'h12); check("R11 mask out", irq_mask_o, 8'h12);
        wr(8'h09, 8'h81); check("R11 dflt out", irq_dflt_o, 8'h81);
        rd(8'h11, rv); check("R11 mask read", rv, 8'h12);

        // R8 synchronized level
        @(negedge clk); pin_in = 8'h3C;
        rd(8'h0F, rv); check("R8 too early", rv, 8'h00);
        repeat (2) @(negedge clk);
        rd(8'h0F, rv); check("R8 level", rv, 8'h3C);
        wr(8'h0F, 8'hFF);
        rd(8'h0F, rv); check("R8 write ignored", rv, 8'h3C);

        // R7 soft reset
        wr(8'h01, 8'h01);
        check("R7 oe", pin_oe, 8'h00);
        check("R7 pu", pin_pu, 8'hFF);
        check("R7 pd", pin_pd, 8'h00);
        check("R7 mask", irq_mask_o, 8'hFF);
        check("R7 dflt", irq_dflt_o, 8'h00);
        rd(8'h05, rv); check("R7 out", rv, 8'h00);
        rd(8'h01, rv); check("R6 flag set by soft reset", rv, 8'hAA);
        rd(8'h01, rv); check("R6 flag cleared again", rv, 8'hA8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule